// File: doc/BRIEF.md
# Per-Bank Activate/Precharge Timing Selector

This block belongs to the command scheduler of a memory controller. It follows every bank through the access cycle of opening a row, reading columns and closing the row again. Banks that showed errors at the present lowered supply voltage are marked in an error map. Each bank then gets its own activate-to-read and precharge delays instead of a single setting for the whole device. A marked bank gets a stretched delay. An unmarked bank keeps the short delay. Each stretched delay is a base cycle count plus a whole number of stretch steps, and one step is the cycle equivalent of 2.5 ns.

Every bank runs its own four-state machine with a down-counter. The states are `BK_IDLE` (precharged and ready), `BK_ACT_WAIT` (counting the activate-to-read delay), `BK_OPEN` (row open and ready) and `BK_PRE_WAIT` (counting the precharge delay). There are four transitions:
- act-start goes from `BK_IDLE` to `BK_ACT_WAIT`.
- act-done goes from `BK_ACT_WAIT` to `BK_OPEN`.
- pre-start goes from `BK_OPEN` to `BK_PRE_WAIT`.
- pre-done goes from `BK_PRE_WAIT` to `BK_IDLE`.

The "-done" transitions fire when the counter has run out. The scheduler issues a command only to a bank whose ready bit is high. A command that breaks the order sets a sticky violation bit for that bank.

A new error map is taken in only when every bank is in `BK_IDLE`. A command in the same cycle as the map write still uses the old map.

Top module: `bank_timing_sel`

## Requirements
- R1: After reset every bank is in `BK_IDLE`: `bank_ready` is all ones, while `bank_open` and `bank_viol` are all zeros.
- R2: An activate (`cmd_type`=1 with `cmd_valid` high) to an idle, unmarked bank drops that bank's ready bit for exactly `RCD_BASE` cycles. After that, ready and open are both high.
- R3: For a bank whose bit is set in the active error map, the activate delay is `RCD_BASE + RCD_STEPS*STEP_CYC` cycles.
- R4: A precharge (`cmd_type`=3) to an open bank drops ready and open at once. Ready comes back after `RP_BASE` cycles for an unmarked bank, or after `RP_BASE + RP_STEPS*STEP_CYC` cycles for a marked bank, and the bank is then idle.
- R5: A read (`cmd_type`=2) to an open, ready bank leaves ready and open high and raises no violation.
- R6: A read to a bank that is not open and ready sets that bank's `bank_viol` bit, and so does an activate to a bank that is not idle and ready. The bit stays set until reset, and the command does not change the bank's state or timing.
- R7: `map_wr` loads `err_map` (bit b marks bank b) only if all banks are idle. Otherwise it is ignored and later delays follow the previous map.
- R8: A command changes only the bank named by `cmd_bank`, and all other banks keep their ready, open and violation values.
- R9: A precharge to an idle bank, or to a bank still counting, is ignored and raises no violation.
- R10: With `cmd_valid` low, `cmd_type` and `cmd_bank` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_type | input | 2 | 0 none, 1 activate, 2 read, 3 precharge |
| cmd_bank | input | log2(NUM_BANKS) | Target bank of the command |
| map_wr | input | 1 | Request to load a new error map |
| err_map | input | NUM_BANKS | Error map, bit b set marks bank b as needing the stretched timing |
| bank_ready | output | NUM_BANKS | Bank may take its next legal command |
| bank_open | output | NUM_BANKS | Bank has an open row and its activate delay has expired |
| bank_viol | output | NUM_BANKS | Sticky flag for a read or activate issued out of order |

## Verification
Two cases are hard to reach from the ports: a map write that lands while all eight banks sit idle, and a map write that lands while a single bank is still busy. Purely random traffic almost never drains every bank at the same time. The random phase therefore switches, in fixed windows, to a mode that sends only precharges and idle cycles. The banks close one by one, and random map writes then meet both the accepted and the refused case. Directed steps also refuse a map write while one bank is open and then measure that bank's precharge delay, which shows that the map was not replaced.

// File: rtl/bts_pkg.sv
package bts_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_ACT = 2'd1,
        CMD_RD  = 2'd2,
        CMD_PRE = 2'd3
    } bts_cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE,
        BK_ACT_WAIT,
        BK_OPEN,
        BK_PRE_WAIT
    } bts_bank_state_e;

endpackage

// File: rtl/bts_delay_sel.sv
module bts_delay_sel #(
    parameter int NUM_BANKS = 8,
    parameter int CNT_W     = 8,
    parameter int RCD_BASE  = 50,
    parameter int RP_BASE   = 50,
    parameter int STEP_CYC  = 10,
    parameter int RCD_STEPS = 2,
    parameter int RP_STEPS  = 2
) (
    input  logic [NUM_BANKS-1:0]            map_q,
    output logic [NUM_BANKS-1:0][CNT_W-1:0] rcd_dly,
    output logic [NUM_BANKS-1:0][CNT_W-1:0] rp_dly
);

    localparam int RCD_LONG = RCD_BASE + RCD_STEPS * STEP_CYC;
    localparam int RP_LONG  = RP_BASE + RP_STEPS * STEP_CYC;
    localparam logic [CNT_W-1:0] RCD_S = CNT_W'(RCD_BASE);
    localparam logic [CNT_W-1:0] RCD_L = CNT_W'(RCD_LONG);
    localparam logic [CNT_W-1:0] RP_S  = CNT_W'(RP_BASE);
    localparam logic [CNT_W-1:0] RP_L  = CNT_W'(RP_LONG);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
        always_comb begin
            rcd_dly[b] = map_q[b] ? RCD_L : RCD_S;
            rp_dly[b]  = map_q[b] ? RP_L  : RP_S;
        end
    end

endmodule

// File: rtl/bts_map_reg.sv
module bts_map_reg #(
    parameter int NUM_BANKS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 map_wr,
    input  logic [NUM_BANKS-1:0] err_map,
    input  logic                 all_idle,
    output logic [NUM_BANKS-1:0] map_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= '0;
        end else if (map_wr && all_idle) begin
            map_q <= err_map;
        end
    end

    // R7: the map only moves after a cycle with every bank precharged
    p_map_only_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(map_q) |-> $past(all_idle) && $past(map_wr));

endmodule

// File: rtl/bts_bank_fsm.sv
module bts_bank_fsm
    import bts_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_hit,
    input  bts_cmd_e         cmd,
    input  logic [CNT_W-1:0] rcd_dly,
    input  logic [CNT_W-1:0] rp_dly,
    output logic             ready,
    output logic             open,
    output logic             idle,
    output logic             viol
);

    bts_bank_state_e  state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             bad;
    logic             viol_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BK_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        bad     = 1'b0;
        unique case (state_q)
            BK_IDLE: begin
                if (cmd_hit && cmd == CMD_ACT) begin
                    state_d = BK_ACT_WAIT;
                    cnt_d   = rcd_dly - 1'b1;
                end else if (cmd_hit && cmd == CMD_RD) begin
                    bad = 1'b1;
                end
            end
            BK_ACT_WAIT: begin
                if (cmd_hit && (cmd == CMD_ACT || cmd == CMD_RD)) begin
                    bad = 1'b1;
                end
                if (cnt_q == '0) begin
                    state_d = BK_OPEN;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            BK_OPEN: begin
                if (cmd_hit && cmd == CMD_PRE) begin
                    state_d = BK_PRE_WAIT;
                    cnt_d   = rp_dly - 1'b1;
                end else if (cmd_hit && cmd == CMD_ACT) begin
                    bad = 1'b1;
                end
            end
            BK_PRE_WAIT: begin
                if (cmd_hit && (cmd == CMD_ACT || cmd == CMD_RD)) begin
                    bad = 1'b1;
                end
                if (cnt_q == '0) begin
                    state_d = BK_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = BK_IDLE;
        endcase
    end

    // sticky violation flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_q <= 1'b0;
        end else if (bad) begin
            viol_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        ready = 1'b0;
        open  = 1'b0;
        idle  = 1'b0;
        unique case (state_q)
            BK_IDLE:     begin ready = 1'b1; idle = 1'b1; end
            BK_OPEN:     begin ready = 1'b1; open = 1'b1; end
            BK_ACT_WAIT: ready = 1'b0;
            BK_PRE_WAIT: ready = 1'b0;
            default:     ready = 1'b0;
        endcase
        viol = viol_q;
    end

    // R2: an accepted activate drops ready on the next cycle
    p_act_drops_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && cmd == CMD_ACT && state_q == BK_IDLE) |=> !ready && !open);

    // R4: an expired precharge count returns the bank to idle
    p_pre_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BK_PRE_WAIT && cnt_q == '0) |=> ready && !open);

    // R5: a read to an open bank keeps it open
    p_read_keeps_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && cmd == CMD_RD && open) |=> open && ready);

    // R6: once set, the violation flag stays
    p_viol_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> viol);

    // R9: a precharge to an idle bank leaves it idle
    p_idle_pre_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && cmd == CMD_PRE && idle) |=> idle && $stable(viol));

endmodule

// File: rtl/bank_timing_sel.sv
module bank_timing_sel
    import bts_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int CNT_W     = 8,
    parameter int RCD_BASE  = 50,
    parameter int RP_BASE   = 50,
    parameter int STEP_CYC  = 10,
    parameter int RCD_STEPS = 2,
    parameter int RP_STEPS  = 2,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_type,
    input  logic [BANK_W-1:0]    cmd_bank,
    input  logic                 map_wr,
    input  logic [NUM_BANKS-1:0] err_map,
    output logic [NUM_BANKS-1:0] bank_ready,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic [NUM_BANKS-1:0] bank_viol
);

    logic [NUM_BANKS-1:0]            map_q;
    logic [NUM_BANKS-1:0]            idle_vec;
    logic [NUM_BANKS-1:0][CNT_W-1:0] rcd_dly;
    logic [NUM_BANKS-1:0][CNT_W-1:0] rp_dly;
    logic                            all_idle;
    bts_cmd_e                        cmd;

    assign all_idle = &idle_vec;
    assign cmd      = bts_cmd_e'(cmd_type);

    bts_map_reg #(.NUM_BANKS(NUM_BANKS)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .map_wr   (map_wr),
        .err_map  (err_map),
        .all_idle (all_idle),
        .map_q    (map_q)
    );

    bts_delay_sel #(
        .NUM_BANKS (NUM_BANKS),
        .CNT_W     (CNT_W),
        .RCD_BASE  (RCD_BASE),
        .RP_BASE   (RP_BASE),
        .STEP_CYC  (STEP_CYC),
        .RCD_STEPS (RCD_STEPS),
        .RP_STEPS  (RP_STEPS)
    ) u_dly (
        .map_q   (map_q),
        .rcd_dly (rcd_dly),
        .rp_dly  (rp_dly)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = cmd_valid && (cmd_bank == BANK_W'(b));

        bts_bank_fsm #(.CNT_W(CNT_W)) u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .cmd_hit (hit),
            .cmd     (cmd),
            .rcd_dly (rcd_dly[b]),
            .rp_dly  (rp_dly[b]),
            .ready   (bank_ready[b]),
            .open    (bank_open[b]),
            .idle    (idle_vec[b]),
            .viol    (bank_viol[b])
        );
    end

    // R8: at most one bank can lose its ready bit per cycle
    p_single_bank_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0($past(bank_ready) & ~bank_ready));

    // R10: without a valid command no bank starts counting
    p_no_cmd_no_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> (bank_ready | ~$past(bank_ready)) == '1);

endmodule

// File: tb/test_bank_timing_sel.sv
module test_bank_timing_sel;

    localparam int NB        = 8;
    localparam int RCD_BASE  = 50;
    localparam int RP_BASE   = 50;
    localparam int STEP_CYC  = 10;
    localparam int RCD_STEPS = 2;
    localparam int RP_STEPS  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_type = 2'd0;
    logic [2:0]    cmd_bank = 3'd0;
    logic          map_wr = 1'b0;
    logic [NB-1:0] err_map = '0;
    logic [NB-1:0] bank_ready, bank_open, bank_viol;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bank_timing_sel #(
        .NUM_BANKS(NB), .CNT_W(8), .RCD_BASE(RCD_BASE), .RP_BASE(RP_BASE),
        .STEP_CYC(STEP_CYC), .RCD_STEPS(RCD_STEPS), .RP_STEPS(RP_STEPS)
    ) i_bank_timing_sel (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
        .cmd_bank(cmd_bank), .map_wr(map_wr), .err_map(err_map),
        .bank_ready(bank_ready), .bank_open(bank_open), .bank_viol(bank_viol)
    );

    function automatic int exp_act(bit flagged);
        return RCD_BASE + (flagged ? RCD_STEPS * STEP_CYC : 0);
    endfunction

    function automatic int exp_pre(bit flagged);
        return RP_BASE + (flagged ? RP_STEPS * STEP_CYC : 0);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a negedge; one command cycle, returns at the next negedge
    task automatic drive(input bit v, input logic [1:0] t, input int b,
                         input bit w, input logic [NB-1:0] m);
        cmd_valid = v;
        cmd_type  = t;
        cmd_bank  = 3'(b);
        map_wr    = w;
        err_map   = m;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_type  = 2'd0;
        map_wr    = 1'b0;
    endtask

    task automatic wait_ready(input int b, output int n);
        n = 0;
        while (!bank_ready[b] && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    int st  [NB];
    int rem [NB];
    bit mv  [NB];
    logic [NB-1:0] mmap;

    initial begin
        int n;
        void'($urandom(32'd2024));
        do_reset();

        // R1 reset state
        chk(bank_ready == '1, "R1 ready", int'(bank_ready), 255);
        chk(bank_open == '0, "R1 open", int'(bank_open), 0);
        chk(bank_viol == '0, "R1 viol", int'(bank_viol), 0);

        // R2 short activate on bank 0
        drive(1, 2'd1, 0, 0, '0);
        chk(bank_ready[7:1] == '1, "R8 other banks ready", int'(bank_ready), 254);
        wait_ready(0, n);
        chk(n == exp_act(0), "R2 short act delay", n, exp_act(0));
        chk(bank_open[0], "R2 open after act", int'(bank_open[0]), 1);

        // R5 read to open bank
        drive(1, 2'd2, 0, 0, '0);
        chk(bank_open[0] && bank_ready[0] && !bank_viol[0], "R5 read ok",
            int'({bank_open[0], bank_ready[0], bank_viol[0]}), 6);

        // R4 short precharge
        drive(1, 2'd3, 0, 0, '0);
        chk(!bank_open[0], "R4 open drops", int'(bank_open[0]), 0);
        wait_ready(0, n);
        chk(n == exp_pre(0), "R4 short pre delay", n, exp_pre(0));

        // R7 map accepted when idle, R3 long activate on bank 2
        drive(0, 2'd0, 0, 1, 8'b0000_0100);
        drive(1, 2'd1, 2, 0, '0);
        drive(1, 2'd2, 2, 0, '0);
        chk(bank_viol == 8'b0000_0100, "R6 read during act wait", int'(bank_viol), 4);
        wait_ready(2, n);
        chk(n == exp_act(1) - 1, "R3 long act delay", n + 1, exp_act(1));
        drive(1, 2'd3, 2, 0, '0);
        wait_ready(2, n);
        chk(n == exp_pre(1), "R4 long pre delay", n, exp_pre(1));

        // R7 map write refused while bank 1 is open
        drive(1, 2'd1, 1, 0, '0);
        wait_ready(1, n);
        drive(0, 2'd0, 0, 1, 8'b0000_0010);
        drive(1, 2'd3, 1, 0, '0);
        wait_ready(1, n);
        chk(n == exp_pre(0), "R7 map ignored while busy", n, exp_pre(0));
        drive(1, 2'd1, 3, 0, '0);
        wait_ready(3, n);
        chk(n == exp_act(0), "R7 old map kept", n, exp_act(0));

        // R6 activate to open bank
        drive(1, 2'd1, 3, 0, '0);
        chk(bank_viol[3] && bank_open[3] && bank_ready[3], "R6 act to open bank",
            int'(bank_viol), 12);

        // R9 precharge to idle bank, R10 invalid command
        drive(1, 2'd3, 4, 0, '0);
        chk(bank_ready[4] && !bank_viol[4], "R9 pre to idle ignored", int'(bank_ready[4]), 1);
        drive(0, 2'd1, 5, 0, '0);
        chk(bank_ready[5] && !bank_open[5], "R10 invalid cmd ignored", int'(bank_ready[5]), 1);
        repeat (5) @(negedge clk);
        chk(bank_viol == 8'b0000_1100, "R6 viol sticky", int'(bank_viol), 12);

        // constrained random against a bench model
        do_reset();
        for (int b = 0; b < NB; b++) begin st[b] = 0; rem[b] = 0; mv[b] = 0; end
        mmap = '0;
        for (int i = 0; i < 6000; i++) begin
            logic [NB-1:0] er, eo, ev, m;
            bit v, w, aidle;
            int t, bk;
            for (int b = 0; b < NB; b++) begin
                er[b] = (st[b] == 0 || st[b] == 2);
                eo[b] = (st[b] == 2);
                ev[b] = mv[b];
            end
            chk(bank_ready == er, "R2 R4 R8 random ready", int'(bank_ready), int'(er));
            chk(bank_open == eo, "R2 R4 random open", int'(bank_open), int'(eo));
            chk(bank_viol == ev, "R6 random viol", int'(bank_viol), int'(ev));
            v  = ($urandom % 4) != 0;
            t  = $urandom % 4;
            bk = $urandom % NB;
            w  = ($urandom % 8) == 0;
            m  = NB'($urandom);
            if ((i % 500) >= 350) begin
                t = ($urandom % 2 == 0) ? 3 : 0;
            end
            aidle = 1'b1;
            for (int b = 0; b < NB; b++) if (st[b] != 0) aidle = 1'b0;
            for (int b = 0; b < NB; b++) begin
                bit hit;
                hit = v && bk == b;
                if (st[b] == 1 || st[b] == 3) begin
                    if (hit && (t == 1 || t == 2)) mv[b] = 1;
                    rem[b]--;
                    if (rem[b] == 0) st[b] = (st[b] == 1) ? 2 : 0;
                end else if (st[b] == 0) begin
                    if (hit && t == 1) begin st[b] = 1; rem[b] = exp_act(mmap[b]); end
                    else if (hit && t == 2) mv[b] = 1;
                end else begin
                    if (hit && t == 3) begin st[b] = 3; rem[b] = exp_pre(mmap[b]); end
                    else if (hit && t == 1) mv[b] = 1;
                end
            end
            if (w && aidle) mmap = m;
            drive(v, 2'(t), bk, w, m);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule